// File: doc/BRIEF.md
# Boundary-Test Access Port with Identification Register

This block is the serial test port of a chip. It runs the sixteen-state test controller from the test clock and mode-select line. It also holds a four-bit instruction register and two data registers: a 32-bit identification register with the value 0xC3631093 and a one-bit bypass register. A host moves the controller through its states with the mode-select line, shifts data in on the serial input and reads data back on the serial output.

The serial output is registered on the falling test-clock edge. The output enable is registered on that same edge. The enable is raised only when the controller sits in one of the two shift states. The last bit of a scan is clocked out on the rising edge that moves the controller into Exit1. That bit was already placed on the output at the falling edge before that rising edge. The pin is released only at the falling edge that follows, so the host can sample every bit, the last one included, on its rising edge.

Top module: `jtag_idcode_tap`

## Requirements
- R1: With trst_n low the controller is forced at once, without a clock, into Test-Logic-Reset. The enable tdo_oe drops to 0 and the instruction register holds the identification opcode 4'b0010, so the next data scan returns 0xC3631093.
- R2: Five rising edges in a row with tms=1 bring the controller from any state into Test-Logic-Reset, which reloads the identification opcode.
- R3: tdo_oe is 1 only during a clock period that follows a falling edge seen in Shift-IR or Shift-DR, and it is 0 in every other state, Capture, Exit1 and Pause included.
- R4: tdo and tdo_oe change only on falling tck edges; they never change at a rising edge.
- R5: In Capture-DR with the identification opcode selected, the data register loads 0xC3631093. It shifts right, bit 0 first, and all 32 bits appear on tdo, including bit 31 when the 32nd shift edge also enters Exit1-DR.
- R6: In a shift state tdi is taken on the rising edge into the most significant bit of the selected register, so that bits shifted beyond the register length return the earlier tdi values.
- R7: Capture-IR loads the binary pattern 0001 into the instruction shift stage, which appears on tdo as 1,0,0,0.
- R8: A shifted instruction takes effect only at Update-IR. Opcode 4'b0010 selects the identification register; every other code selects the bypass register, which captures 0 and delays tdi by one bit.
- R9: A scan may pass through Exit1-DR, Pause-DR and Exit2-DR back into Shift-DR. tdo_oe is 0 during the pause, and the scan resumes with the next unread bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for the tdo pad driver; 0 means high impedance |

## Verification
The hardest case to reach is the boundary at the end of a scan. The shift edge that moves out the last bit is also the edge that leaves the shift state, and the output must stay driven for exactly the half period that follows. The bench reaches this case with scans whose last shift carries tms=1. It samples tdo and tdo_oe just before each rising edge and again just after it. For every one of the sixteen opcodes, it loads the opcode and runs a 40-bit data scan, so the bits beyond the register length and the enable at Exit1 are checked in both register choices. A separate scan pauses halfway through. Random state walks followed by five tms=1 clocks confirm the return to the reset instruction.

// File: rtl/jtag_idcode_tap.sv
module jtag_idcode_tap #(
  parameter int          IR_BITS  = 4,
  parameter int          ID_BITS  = 32,
  parameter logic [31:0] ID_VALUE = 32'hC3631093,
  parameter logic [3:0]  OP_IDENT = 4'b0010
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe
);

  localparam logic [IR_BITS-1:0] IR_CAPTURE = IR_BITS'(1);
  localparam logic [IR_BITS-1:0] OP_ID      = OP_IDENT[IR_BITS-1:0];

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SEL_DR = 4'd2, SEL_IR = 4'd3,
    CAP_IR = 4'd4, SH_IR = 4'd5, EX1_IR = 4'd6, PAU_IR = 4'd7,
    EX2_IR = 4'd8, UPD_IR = 4'd9, CAP_DR = 4'd10, SH_DR = 4'd11,
    EX1_DR = 4'd12, PAU_DR = 4'd13, EX2_DR = 4'd14, UPD_DR = 4'd15
  } tap_t;

  tap_t state, nxt;
  logic [IR_BITS-1:0] ir_sh, ir_q;
  logic [ID_BITS-1:0] id_sh;
  logic               byp;
  logic               id_sel, out_bit, in_shift;

  always_comb begin
    unique case (state)
      TLR:    nxt = tms ? TLR    : RTI;
      RTI:    nxt = tms ? SEL_DR : RTI;
      SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
      SEL_IR: nxt = tms ? TLR    : CAP_IR;
      CAP_IR: nxt = tms ? EX1_IR : SH_IR;
      SH_IR:  nxt = tms ? EX1_IR : SH_IR;
      EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR: nxt = tms ? UPD_IR : SH_IR;
      UPD_IR: nxt = tms ? SEL_DR : RTI;
      CAP_DR: nxt = tms ? EX1_DR : SH_DR;
      SH_DR:  nxt = tms ? EX1_DR : SH_DR;
      EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR: nxt = tms ? UPD_DR : SH_DR;
      UPD_DR: nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= TLR;
    else         state <= nxt;

  assign id_sel   = (ir_q == OP_ID);
  assign in_shift = (state == SH_IR) || (state == SH_DR);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_ID;
    end else begin
      if (state == CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (state == SH_IR) ir_sh <= {tdi, ir_sh[IR_BITS-1:1]};
      if (state == TLR)        ir_q <= OP_ID;
      else if (state == UPD_IR) ir_q <= ir_sh;
    end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      id_sh <= '0;
      byp   <= 1'b0;
    end else if (state == CAP_DR) begin
      if (id_sel) id_sh <= ID_VALUE[ID_BITS-1:0];
      else        byp   <= 1'b0;
    end else if (state == SH_DR) begin
      if (id_sel) id_sh <= {tdi, id_sh[ID_BITS-1:1]};
      else        byp   <= tdi;
    end

  assign out_bit = (state == SH_IR) ? ir_sh[0] : (id_sel ? id_sh[0] : byp);

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift;
      if (in_shift) tdo <= out_bit;
    end

  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)           ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q == 3'd5) |-> (state == TLR));

  assert_oe_only_shift_R3: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == SH_IR) || (state == SH_DR)));

  assert_ir_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_IR) |=> (ir_sh == IR_CAPTURE));

  assert_ir_hold_R8: assert property (@(posedge tck) disable iff (!trst_n)
    !((state == UPD_IR) || (state == TLR)) |=> $stable(ir_q));

  assert_id_load_R5: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == CAP_DR) && id_sel) |=> (id_sh == ID_VALUE[ID_BITS-1:0]));

endmodule

// File: tb/test_jtag_idcode_tap.sv
module test_jtag_idcode_tap;
  localparam logic [31:0] IDV = 32'hC3631093;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  jtag_idcode_tap i_jtag_idcode_tap (.tck(tck), .trst_n(trst_n), .tms(tms),
    .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe));

  always #5 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o_tdo, output logic o_oe);
    @(negedge tck); #1; tms = m; tdi = d;
    #3; o_tdo = tdo; o_oe = tdo_oe;
    @(posedge tck); #1;
    chk("R4 tdo stable at rise", {63'd0, tdo}, {63'd0, o_tdo});
    chk("R4 oe stable at rise", {63'd0, tdo_oe}, {63'd0, o_oe});
  endtask

  task automatic go(input logic m);
    logic a, b;
    tick(m, 1'b0, a, b);
  endtask

  task automatic ir_scan(input logic [3:0] op);
    logic t, e;
    logic [3:0] got;
    go(1); go(1); go(0);
    tick(0, 0, t, e);
    chk("R3 oe in Capture-IR", {63'd0, e}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i], t, e);
      got[i] = t;
      chk("R3 oe in Shift-IR", {63'd0, e}, 64'd1);
    end
    chk("R7 captured IR pattern", {60'd0, got}, 64'd1);
    tick(1, 0, t, e);
    chk("R3 oe in Exit1-IR", {63'd0, e}, 64'd0);
    go(0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] got);
    logic t, e;
    got = '0;
    go(1); go(0);
    tick(0, 0, t, e);
    chk("R3 oe in Capture-DR", {63'd0, e}, 64'd0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], t, e);
      got[i] = t;
      chk("R3 oe in Shift-DR", {63'd0, e}, 64'd1);
    end
    tick(1, 0, t, e);
    chk("R3 oe in Exit1-DR", {63'd0, e}, 64'd0);
    go(0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, din, exp;
    logic t, e;
    #12;
    chk("R1 oe under reset", {63'd0, tdo_oe}, 64'd0);
    trst_n = 1'b1;
    go(0);
    dr_scan(32, 64'd0, got);
    chk("R1 R5 IDCODE after reset", got, {32'd0, IDV});

    for (int op = 0; op < 16; op++) begin
      ir_scan(4'(op));
      din = '0;
      for (int i = 0; i < 40; i++) din[i] = ((i * 7 + op) % 3) == 0;
      dr_scan(40, din, got);
      exp = '0;
      for (int i = 0; i < 40; i++)
        if (op == 2) exp[i] = (i < 32) ? IDV[i] : din[i - 32];
        else         exp[i] = (i == 0) ? 1'b0 : din[i - 1];
      chk(op == 2 ? "R5 R6 R8 identification scan" : "R6 R8 bypass scan", got, exp);
    end

    for (int k = 0; k < 16; k++) begin
      ir_scan(4'hF);
      for (int j = 0; j < 6; j++) go(1'((k * 5 + j * 3) >> (j % 3)));
      for (int j = 0; j < 5; j++) go(1);
      go(0);
      dr_scan(32, 64'd0, got);
      chk("R2 five ones restore IDCODE", got, {32'd0, IDV});
    end

    got = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, 0, t, e);
      got[i] = t;
    end
    for (int p = 0; p < 3; p++) begin
      tick(0, 0, t, e);
      chk("R9 oe low in Exit1/Pause", {63'd0, e}, 64'd0);
    end
    go(1);
    tick(0, 0, t, e);
    chk("R9 oe low in Exit2", {63'd0, e}, 64'd0);
    for (int i = 10; i < 32; i++) begin
      tick(i == 31, 0, t, e);
      got[i] = t;
      chk("R9 oe after resume", {63'd0, e}, 64'd1);
    end
    go(1); go(0);
    chk("R9 paused scan data", got, {32'd0, IDV});

    ir_scan(4'hF);
    go(1); go(0); go(0);
    go(0); go(0);
    #2;
    trst_n = 1'b0;
    #1;
    chk("R1 async reset drops oe", {63'd0, tdo_oe}, 64'd0);
    #20;
    trst_n = 1'b1;
    go(0);
    dr_scan(32, 64'd0, got);
    chk("R1 IDCODE selected after trst", got, {32'd0, IDV});

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule